// File: doc/BRIEF.md
# Packed Instruction Word Unpacker

This block turns a stream of 16-bit transfer words into a stream of 24-bit instruction words. On the wire, instruction words travel in pairs that share a transfer word. The low 16 bits of the first instruction come first. Next comes a shared word that holds the upper bytes of both instructions. The low 16 bits of the second instruction come last. Three transfer words therefore carry two instructions.

A job begins with a start strobe and a count of instruction words. The unpacker then takes transfer words over a valid/ready handshake. It presents each rebuilt instruction on a valid/ready output and marks the final one with a last flag. When the count is odd, the final group is shortened: only the low word and the shared word are sent. The upper byte of the missing instruction should then be zero, and a nonzero byte sets a sticky format-error flag. A one-cycle done pulse closes every job, including a job with a count of zero.

Top module: `instr_unpacker`

## Requirements
- R1: After reset, out_valid, in_ready, done and fmt_err are all 0.
- R2: The first instruction of a group is emitted once its shared word is accepted. Its value is {shared[7:0], first transfer word of the group}.
- R3: The second instruction of a group is emitted once its low word, the third word of the group, is accepted. Its value is {shared[15:8], that low word}.
- R4: out_last is 1 on the count-th instruction of a job and 0 on every earlier one. Instructions appear in the order they were packed.
- R5: For an odd count, the job ends after the shared word of the final group. No further transfer word is accepted, so exactly 3*count/2 transfer words are consumed, rounded up.
- R6: fmt_err becomes 1 when the final shared word of an odd-count job has a nonzero bits 15:8. It stays 1 until the next accepted start, which clears it.
- R7: A start with count 0 emits no instruction. done is 1 in the cycle after the start edge and 0 in the cycle after that.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0, and out_data and out_last hold their values.
- R9: done is 1 for exactly the one cycle after the handshake of the instruction that carries out_last. In that cycle the block is idle, with in_ready at 0.
- R10: A start strobe that arrives while a job is in progress is ignored. The running job's count and output stream are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a job when the block is idle |
| count | input | CNT_W (12) | Number of instruction words in the job |
| in_data | input | 16 | Transfer word |
| in_valid | input | 1 | in_data is offered |
| in_ready | output | 1 | Transfer word is accepted this cycle if valid |
| out_data | output | 24 | Rebuilt instruction word |
| out_valid | output | 1 | out_data is offered |
| out_ready | input | 1 | Consumer accepts out_data |
| out_last | output | 1 | out_data is the final instruction of the job |
| done | output | 1 | One-cycle pulse at job end |
| fmt_err | output | 1 | Sticky: odd final group had a nonzero filler byte |

## Verification
The embedded assertions watch four things on every cycle: the output holds while stalled, fmt_err is sticky and is cleared only by an accepted start, done follows the final handshake, and a start during a job leaves the job untouched. What only the bench scenarios can show is that the byte positions are right when instructions are rebuilt. The same goes for the order and last-flag placement across random counts and stalls, for the fact that no third word is consumed in odd jobs, and for the case where zero or a stray start arrives mid-job.

// File: rtl/instr_unpack_pkg.sv
package instr_unpack_pkg;
  localparam int XFER_W  = 16;
  localparam int HALF_W  = XFER_W / 2;
  localparam int INSTR_W = XFER_W + HALF_W;

  typedef enum logic [1:0] {
    PH_LOW1   = 2'd0,
    PH_SHARED = 2'd1,
    PH_LOW2   = 2'd2
  } phase_e;

  // first instruction of a group: shared low byte on top of its low word
  function automatic logic [INSTR_W-1:0] join_first(input logic [XFER_W-1:0] shared,
                                                    input logic [XFER_W-1:0] low);
    return {shared[HALF_W-1:0], low};
  endfunction

  // second instruction: saved upper byte on top of the trailing low word
  function automatic logic [INSTR_W-1:0] join_second(input logic [HALF_W-1:0] hi,
                                                     input logic [XFER_W-1:0] low);
    return {hi, low};
  endfunction

  function automatic logic [HALF_W-1:0] upper_of(input logic [XFER_W-1:0] shared);
    return shared[XFER_W-1:HALF_W];
  endfunction
endpackage

// File: rtl/unpack_seq.sv
module unpack_seq
  import instr_unpack_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             take,
  input  logic             fin,
  output phase_e           phase,
  output logic             active,
  output logic             final_word,
  output logic             job_accept,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remaining;

  assign job_accept = start && !active;
  assign final_word = (remaining == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      phase     <= PH_LOW1;
      remaining <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (job_accept) begin
        if (count == '0) begin
          done <= 1'b1;
        end else begin
          active    <= 1'b1;
          remaining <= count;
          phase     <= PH_LOW1;
        end
      end else if (fin) begin
        active <= 1'b0;
        done   <= 1'b1;
        phase  <= PH_LOW1;
      end else if (take) begin
        unique case (phase)
          PH_LOW1: phase <= PH_SHARED;
          PH_SHARED: begin
            remaining <= remaining - ONE;
            phase     <= final_word ? PH_LOW1 : PH_LOW2;
          end
          default: begin
            remaining <= remaining - ONE;
            phase     <= PH_LOW1;
          end
        endcase
      end
    end
  end

  assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    job_accept && (count == '0) |=> done && !active);

  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> done && !active);

  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start && active && !take && !fin |=> active && $stable(remaining) && $stable(phase));

  assert_idle_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> phase == PH_LOW1);
endmodule

// File: rtl/unpack_outreg.sv
module unpack_outreg
  import instr_unpack_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [INSTR_W-1:0] load_data,
  input  logic               load_last,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [INSTR_W-1:0] out_data,
  output logic               out_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      out_last  <= load_last;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_while_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
endmodule

// File: rtl/instr_unpacker.sv
module instr_unpacker
  import instr_unpack_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   count,
  input  logic [XFER_W-1:0]  in_data,
  input  logic               in_valid,
  output logic               in_ready,
  output logic [INSTR_W-1:0] out_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_last,
  output logic               done,
  output logic               fmt_err
);
  phase_e             phase;
  logic               active;
  logic               final_word;
  logic               job_accept;
  logic               take;
  logic               fin;
  logic               load;
  logic [INSTR_W-1:0] load_data;
  logic [XFER_W-1:0]  low_q;
  logic [HALF_W-1:0]  hi_q;
  logic               odd_tail_bad;

  // named events shared by the logic and the assertions
  assign in_ready     = active && !out_valid;
  assign take         = in_valid && in_ready;
  assign fin          = out_valid && out_ready && out_last;
  assign load         = take && (phase != PH_LOW1);
  assign load_data    = (phase == PH_SHARED) ? join_first(in_data, low_q)
                                             : join_second(hi_q, in_data);
  assign odd_tail_bad = take && (phase == PH_SHARED) && final_word
                        && (upper_of(in_data) != '0);

  unpack_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .count      (count),
    .take       (take),
    .fin        (fin),
    .phase      (phase),
    .active     (active),
    .final_word (final_word),
    .job_accept (job_accept),
    .done       (done)
  );

  unpack_outreg u_outreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (load_data),
    .load_last (final_word),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= '0;
      hi_q    <= '0;
      fmt_err <= 1'b0;
    end else begin
      if (take && phase == PH_LOW1)   low_q <= in_data;
      if (take && phase == PH_SHARED) hi_q  <= upper_of(in_data);
      if (job_accept)        fmt_err <= 1'b0;
      else if (odd_tail_bad) fmt_err <= 1'b1;
    end
  end

  assert_fmt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err && !job_accept |=> fmt_err);

  assert_fmt_cleared_by_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    job_accept |=> !fmt_err);

  assert_no_input_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !in_ready && !out_valid);

  assert_last_needs_final_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load && !final_word |=> !out_last);
endmodule

// File: tb/instr_unpacker_bench.sv
`timescale 1ns/1ps
module instr_unpacker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] count = '0;
  logic [15:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_last;
  logic        done;
  logic        fmt_err;

  int tests = 0;
  int fails = 0;
  bit sink_end;

  always #2.5 clk = ~clk;

  instr_unpacker u_instr_unpacker (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .done(done), .fmt_err(fmt_err)
  );

  // bench-side packing, by arithmetic rather than slicing
  function automatic logic [15:0] low_part(input logic [23:0] w);
    return 16'(w % 65536);
  endfunction
  function automatic logic [7:0] top_byte(input logic [23:0] w);
    return 8'(w / 65536);
  endfunction
  function automatic logic [15:0] shared_of(input logic [7:0] hi_first, input logic [7:0] hi_second);
    return 16'(hi_second * 256 + hi_first);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic run_job(input int n, input bit bad_tail, input int in_gap,
                         input int stall, input bit poke);
    logic [23:0] words[$];
    logic [15:0] stream[$];
    int idx;
    int extra;
    words.delete();
    stream.delete();
    for (int i = 0; i < n; i++) words.push_back(24'($urandom));
    for (int k = 0; k < n; k += 2) begin
      logic [7:0] h2;
      stream.push_back(low_part(words[k]));
      h2 = (k + 1 < n) ? top_byte(words[k+1]) : (bad_tail ? 8'hA5 : 8'h00);
      stream.push_back(shared_of(top_byte(words[k]), h2));
      if (k + 1 < n) stream.push_back(low_part(words[k+1]));
    end
    sink_end = 1'b0;
    idx = 0;
    extra = 0;
    @(negedge clk); start = 1'b1; count = 12'(n);
    @(negedge clk); start = 1'b0;
    #1 check(fmt_err == 1'b0, "R6", "cleared by start", 32'(fmt_err), 0);
    fork
      begin : feeder
        while (!sink_end) begin
          @(negedge clk);
          if (idx < stream.size()) begin
            in_valid = (($urandom % 100) >= 32'(in_gap));
            in_data  = stream[idx];
          end else begin
            in_valid = 1'b1;
            in_data  = 16'hDEAD;
          end
          #1;
          if (in_valid && in_ready) begin
            if (idx < stream.size()) idx++;
            else extra++;
          end
        end
        in_valid = 1'b0;
      end
      begin : sink
        int got = 0;
        bit held = 1'b0;
        logic [23:0] held_data = '0;
        while (got < n) begin
          @(negedge clk);
          out_ready = (($urandom % 100) >= 32'(stall));
          #1;
          if (out_valid) begin
            if (held) check(out_data == held_data, "R8", "held data", 32'(out_data), 32'(held_data));
            if (!out_ready) begin
              check(in_ready == 1'b0, "R8", "in_ready in stall", 32'(in_ready), 0);
              held = 1'b1;
              held_data = out_data;
            end else begin
              held = 1'b0;
              check(out_data == words[got], (got % 2 == 0) ? "R2" : "R3", "instruction",
                    32'(out_data), 32'(words[got]));
              check(out_last == (got == n - 1), "R4", "last flag", 32'(out_last), 32'(got == n - 1));
              got++;
            end
          end
        end
        sink_end = 1'b1;
        @(negedge clk); out_ready = 1'b0;
        #1 check(done == 1'b1, "R9", "done after last", 32'(done), 1);
        check(in_ready == 1'b0 && out_valid == 1'b0, "R9", "idle after last",
              32'({in_ready, out_valid}), 0);
        @(negedge clk);
        #1 check(done == 1'b0, "R9", "done one cycle", 32'(done), 0);
      end
      begin : poker
        if (poke) begin
          repeat (4) @(negedge clk);
          start = 1'b1; count = 12'd3;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
    check(idx == stream.size(), poke ? "R10" : "R5", "words consumed", 32'(idx), 32'(stream.size()));
    check(extra == 0, "R5", "no extra word taken", 32'(extra), 0);
    check(fmt_err == ((n % 2 == 1) && bad_tail), "R6", "format flag", 32'(fmt_err),
          32'((n % 2 == 1) && bad_tail));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    #1 check({out_valid, in_ready, done, fmt_err} == 4'b0, "R1", "reset outputs",
             32'({out_valid, in_ready, done, fmt_err}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check({out_valid, in_ready, done, fmt_err} == 4'b0, "R1", "idle after reset",
             32'({out_valid, in_ready, done, fmt_err}), 0);

    // directed corners
    run_job(1, 1'b1, 0, 0, 1'b0);    // R5 R6: single odd word with bad filler
    check(fmt_err == 1'b1, "R6", "sticky while idle", 32'(fmt_err), 1);
    run_job(2, 1'b0, 0, 0, 1'b0);    // R3: one full group
    run_job(3, 1'b0, 30, 60, 1'b0);  // R5: odd count, heavy stalls
    run_job(5, 1'b1, 0, 80, 1'b0);   // R6 R8
    run_job(8, 1'b0, 10, 20, 1'b1);  // R10: stray start mid-job

    // R7: zero-count job
    @(negedge clk); start = 1'b1; count = 12'd0;
    @(negedge clk); start = 1'b0;
    #1 check(done == 1'b1, "R7", "done for zero count", 32'(done), 1);
    check(out_valid == 1'b0 && in_ready == 1'b0, "R7", "no activity",
          32'({out_valid, in_ready}), 0);
    @(negedge clk);
    #1 check(done == 1'b0, "R7", "done one cycle", 32'(done), 0);
    check(out_valid == 1'b0, "R7", "no output", 32'(out_valid), 0);

    // random jobs
    for (int j = 0; j < 24; j++) begin
      run_job(1 + int'($urandom % 11), 1'($urandom), int'($urandom % 50),
              int'($urandom % 50), 1'b0);
    end
    summary();
  end
endmodule